// File: doc/BRIEF.md
# LCD Panel Scan Timing Generator

This block produces the digital drive pulses for an active-matrix LCD panel whose horizontal and vertical shift-register drivers are built into the glass. It runs from one master clock and is resynchronised by horizontal and vertical sync inputs. From these it derives the following registered outputs:

- a horizontal start pulse with a pair of complementary horizontal shift clocks
- a vertical start pulse with a vertical shift clock
- a per-line gate enable window
- a polarity flag that flips once per line
- the two scan-direction levels

The dots of adjacent rows sit half an RGB triple apart. To sample them correctly, the horizontal start pulse and the shift clocks move later by half a horizontal clock period on odd lines. With the default 12 MHz master clock and four ticks per horizontal clock, that shift is two ticks.

All horizontal timing is counted in master-clock ticks. The count is 0 at the clock edge that first samples `hsync` high, and it then advances by one per edge. It saturates at its maximum value and leaves reset at that maximum. The line index works the same way. It is set to 0 at the edge that first samples `vsync` high, it advances at each `hsync` leading edge, it saturates at its maximum, and it leaves reset at its maximum. Line 0 is even. Every output is registered, so an output decoded from count c appears after the following edge.

Top module: `lcd_scan_timer`

## Requirements
- R1: While `rst_n` is low, the following outputs are low: `h_clk_a`, `h_clk_b`, `h_start`, `gate_en`, `v_start`, `v_clk` and `pol_flip`. Also while `rst_n` is low, `dir_right` and `dir_down` are high.
- R2: Let S = HCLK_START on even lines and S = HCLK_START + TICKS_PER_HCLK/2 on odd lines. For counts S to S + HCLK_PER_LINE×TICKS_PER_HCLK − 1, the horizontal clocks run. `h_clk_a` is high for the first half of each TICKS_PER_HCLK period and `h_clk_b` is high for the second half. Outside that window both are low.
- R3: `h_clk_a` and `h_clk_b` are never high together. Inside the window, exactly one of them is high.
- R4: `h_start` is high for counts S − TICKS_PER_HCLK/2 to S − 1. It therefore falls on the same edge at which `h_clk_a` first rises.
- R5: The odd-line shift of R2 and R4 follows bit 0 of the line index. Lines counted from `vsync` therefore alternate between the unshifted and the shifted timing.
- R6: `pol_flip` inverts once for each `hsync` leading edge and is otherwise stable.
- R7: `v_clk` inverts when the count equals VCLK_AT. It is forced low at a `vsync` leading edge.
- R8: `gate_en` is high for counts EN_AT to EN_AT + EN_TICKS − 1 on every line.
- R9: `v_start` is high from count VSTART_AT of line 0 up to count VSTART_AT − 1 of line 1. It therefore straddles the `v_clk` transition of line 1.
- R10: `dir_right` and `dir_down` follow `cfg_right` and `cfg_down` with one edge of latency. High on `dir_right` means left-to-right scan; high on `dir_down` means top-to-bottom scan.
- R11: When `hsync` is missing, the tick count holds at its maximum and no horizontal clock, start or enable pulse is issued. When `vsync` is missing, the line index holds at its maximum, which is odd, so the shifted timing persists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Horizontal sync, leading edge starts a line |
| vsync | input | 1 | Vertical sync, leading edge restarts the line index |
| cfg_right | input | 1 | Requested horizontal scan direction |
| cfg_down | input | 1 | Requested vertical scan direction |
| h_start | output | 1 | Horizontal shift-register start pulse |
| h_clk_a | output | 1 | Horizontal shift clock, first phase |
| h_clk_b | output | 1 | Horizontal shift clock, complementary phase |
| v_start | output | 1 | Vertical shift-register start pulse |
| v_clk | output | 1 | Vertical shift clock, one transition per line |
| gate_en | output | 1 | Gate selection enable window |
| pol_flip | output | 1 | Line-rate video polarity flag |
| dir_right | output | 1 | Horizontal scan direction level |
| dir_down | output | 1 | Vertical scan direction level |

## Verification
The bench shrinks the block to keep lines short:

- eight horizontal clocks per line, starting at tick 6
- a 7-bit tick count and a 3-bit line index
- 60-tick lines

With these values, a run of a few thousand cycles reaches several behaviours:

- both saturation limits
- the odd-line shift persisting once the line index is exhausted
- a 200-tick line with no sync
- a `vsync` edge arriving mid-line
- a reset in the middle of a line

A behavioural model tracks the ticks since sync and the line index as plain integers. It predicts every output on every clock edge.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int TICKS_PER_HCLK = 4,
  parameter int HCLK_PER_LINE  = 295,
  parameter int HCLK_START     = 40,
  parameter int VCLK_AT        = 20,
  parameter int EN_AT          = 56,
  parameter int EN_TICKS       = 13,
  parameter int VSTART_AT      = 401,
  parameter int CNT_W          = 11,
  parameter int LINE_W         = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  input  logic cfg_right,
  input  logic cfg_down,
  output logic h_start,
  output logic h_clk_a,
  output logic h_clk_b,
  output logic v_start,
  output logic v_clk,
  output logic gate_en,
  output logic pol_flip,
  output logic dir_right,
  output logic dir_down
);

  localparam int HALF = TICKS_PER_HCLK / 2;
  localparam int SPAN = HCLK_PER_LINE * TICKS_PER_HCLK;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  logic              hs_q, vs_q;
  logic [CNT_W-1:0]  tick;
  logic [LINE_W-1:0] line;

  wire hs_edge = hsync & ~hs_q;
  wire vs_edge = vsync & ~vs_q;

  int   t_i, ph_i;
  logic in_win, clk_a_d, start_d, en_d, vstart_d;

  always_comb begin
    t_i      = int'(tick);
    ph_i     = t_i - (HCLK_START + (line[0] ? HALF : 0));
    in_win   = (ph_i >= 0) && (ph_i < SPAN);
    clk_a_d  = in_win && ((ph_i % TICKS_PER_HCLK) < HALF);
    start_d  = (ph_i >= -HALF) && (ph_i < 0);
    en_d     = (t_i >= EN_AT) && (t_i < EN_AT + EN_TICKS);
    vstart_d = (line == '0 && t_i >= VSTART_AT) || (line == LINE_ONE && t_i < VSTART_AT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q      <= 1'b0;
      vs_q      <= 1'b0;
      tick      <= CNT_MAX;
      line      <= LINE_MAX;
      h_start   <= 1'b0;
      h_clk_a   <= 1'b0;
      h_clk_b   <= 1'b0;
      v_start   <= 1'b0;
      v_clk     <= 1'b0;
      gate_en   <= 1'b0;
      pol_flip  <= 1'b0;
      dir_right <= 1'b1;
      dir_down  <= 1'b1;
    end else begin
      hs_q      <= hsync;
      vs_q      <= vsync;
      tick      <= hs_edge ? '0 : (tick == CNT_MAX ? tick : tick + 1'b1);
      line      <= vs_edge ? '0 : ((hs_edge && line != LINE_MAX) ? line + 1'b1 : line);
      h_start   <= start_d;
      h_clk_a   <= clk_a_d;
      h_clk_b   <= in_win & ~clk_a_d;
      v_start   <= vstart_d;
      v_clk     <= vs_edge ? 1'b0 : ((t_i == VCLK_AT) ? ~v_clk : v_clk);
      gate_en   <= en_d;
      pol_flip  <= pol_flip ^ hs_edge;
      dir_right <= cfg_right;
      dir_down  <= cfg_down;
    end
  end

endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic hsync,
  input logic h_start,
  input logic h_clk_a,
  input logic h_clk_b,
  input logic v_clk,
  input logic gate_en,
  input logic pol_flip
);

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_clk_a && h_clk_b));

  a_r4_start_meets_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h_start) |-> $rose(h_clk_a));

  a_r6_flip_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol_flip) |-> $past(hsync));

  a_r8_enable_clear_of_vclk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $stable(v_clk));

endmodule

bind lcd_scan_timer lcd_scan_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .h_start(h_start),
  .h_clk_a(h_clk_a), .h_clk_b(h_clk_b), .v_clk(v_clk),
  .gate_en(gate_en), .pol_flip(pol_flip)
);

// File: tb/lcd_scan_timer_tb.sv
`timescale 1ns/100ps
module lcd_scan_timer_tb;
  localparam int TPH = 4, NCLK = 8, HS = 6, VC = 3, EA = 10, EL = 3, VA = 30;
  localparam int CW = 7, LW = 3;
  localparam int TMAX = (1 << CW) - 1, LMAX = (1 << LW) - 1, HALF = TPH / 2;

  logic clk = 0, rst_n = 0, hsync = 0, vsync = 0, cfg_right = 0, cfg_down = 0;
  logic h_start, h_clk_a, h_clk_b, v_start, v_clk, gate_en, pol_flip, dir_right, dir_down;

  lcd_scan_timer #(.TICKS_PER_HCLK(TPH), .HCLK_PER_LINE(NCLK), .HCLK_START(HS),
    .VCLK_AT(VC), .EN_AT(EA), .EN_TICKS(EL), .VSTART_AT(VA), .CNT_W(CW), .LINE_W(LW))
  u_dut (.clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .cfg_right(cfg_right),
    .cfg_down(cfg_down), .h_start(h_start), .h_clk_a(h_clk_a), .h_clk_b(h_clk_b),
    .v_start(v_start), .v_clk(v_clk), .gate_en(gate_en), .pol_flip(pol_flip),
    .dir_right(dir_right), .dir_down(dir_down));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int t, ln;
  bit hq, vq, m_flip, m_vclk;
  bit e_start, e_a, e_b, e_vs, e_vclk, e_en, e_flip, e_r, e_d;

  // behavioural reference: ticks since hsync, line index since vsync
  always @(posedge clk) begin
    if (!rst_n) begin
      t = TMAX; ln = LMAX; hq = 0; vq = 0; m_flip = 0; m_vclk = 0;
      {e_start, e_a, e_b, e_vs, e_vclk, e_en, e_flip} = '0;
      e_r = 1; e_d = 1;
    end else begin
      automatic bit hr = hsync && !hq;
      automatic bit vr = vsync && !vq;
      automatic int s = HS + ((ln % 2 == 1) ? HALF : 0);
      automatic bit win = (t >= s) && (t < s + NCLK * TPH);
      e_a = win && (((t - s) % TPH) < HALF);
      e_b = win && !e_a;
      e_start = (t >= s - HALF) && (t < s);
      e_en = (t >= EA) && (t < EA + EL);
      e_vs = (ln == 0 && t >= VA) || (ln == 1 && t < VA);
      if (vr) m_vclk = 0; else if (t == VC) m_vclk = !m_vclk;
      if (hr) m_flip = !m_flip;
      e_vclk = m_vclk; e_flip = m_flip;
      e_r = cfg_right; e_d = cfg_down;
      if (hr) t = 0; else if (t < TMAX) t++;
      if (vr) ln = 0; else if (hr && ln < LMAX) ln++;
      hq = hsync; vq = vsync;
    end
  end

  task automatic cmp(input logic act, input bit exp, input string tag, input string nm);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, nm, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      cmp(h_clk_a, 0, "R1", "h_clk_a"); cmp(h_clk_b, 0, "R1", "h_clk_b");
      cmp(h_start, 0, "R1", "h_start"); cmp(gate_en, 0, "R1", "gate_en");
      cmp(v_start, 0, "R1", "v_start"); cmp(v_clk, 0, "R1", "v_clk");
      cmp(pol_flip, 0, "R1", "pol_flip");
      cmp(dir_right, 1, "R1", "dir_right"); cmp(dir_down, 1, "R1", "dir_down");
    end else begin
      cmp(h_clk_a, e_a, "R2/R5", "h_clk_a");
      cmp(h_clk_b, e_b, "R3", "h_clk_b");
      cmp(h_start, e_start, "R4/R5", "h_start");
      cmp(pol_flip, e_flip, "R6", "pol_flip");
      cmp(v_clk, e_vclk, "R7", "v_clk");
      cmp(gate_en, e_en, "R8", "gate_en");
      cmp(v_start, e_vs, "R9", "v_start");
      cmp(dir_right, e_r, "R10", "dir_right");
      cmp(dir_down, e_d, "R10", "dir_down");
    end
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run_line(input int len, input int vs_at);
    for (int k = 0; k < len; k++) begin
      @(negedge clk); #1;
      hsync = (k < 3);
      vsync = (vs_at >= 0) && (k >= vs_at) && (k < vs_at + 3);
      if (len > 150 && k == 160) begin
        // R11: saturated count, no horizontal activity
        cmp(h_clk_a | h_clk_b | h_start | gate_en, 0, "R11", "idle_outputs");
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1 rst_n = 1;
    run_line(60, -1); run_line(60, -1);
    cfg_down = 1;
    run_line(60, 0);
    for (int i = 0; i < 9; i++) run_line(60, -1);
    cfg_right = 1;
    run_line(200, -1);
    run_line(60, 45);
    for (int i = 0; i < 4; i++) run_line(60, -1);
    cfg_down = 0;
    run_line(60, 0);
    run_line(25, -1);
    @(negedge clk); #1 rst_n = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    run_line(60, 0); run_line(60, -1); run_line(60, -1);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule